// File: doc/BRIEF.md
# Comma-Aligning Deserializer with Split Half-Rate Strobes

This block turns a serial 8b/10b bit stream into aligned 10-bit code-groups. A sliding window over the most recent ten bits is searched for a 7-bit comma on every bit clock. When a comma shows up at an offset that differs from the current word boundary, the boundary counter restarts, so that the comma group is the word presented next. Bit 0 of the parallel word is always the earliest bit received.

Words are strobed by two receive clocks that run at one twentieth of the bit rate and are 180 degrees apart. Groups alternate between an even slot, which raises the even strobe, and an odd slot, which raises the odd strobe. A comma group is always forced into the even slot. When realignment moves the boundary, a strobe level is held for extra bit times rather than cut short, so no strobe level lasts less than ten bit times. A detect flag marks comma words. An enable input lets alignment move or freezes it. A wrap input feeds the block's own transmit bit stream into the deserializer in place of the line, and the transmit stream is still passed on to the serial output.

All logic runs on one bit-rate clock. The two strobes are registered outputs.

Top module: `comma_deser`

## Requirements
- R1: When `wrap_en` is 1 the deserializer shifts in `tx_bit`; when it is 0 it shifts in `line_bit`, and `tx_bit` has no effect on `rx_word` or `comma_det`.
- R2: `rx_word` bit i is the i-th received bit of a group (bit 0 earliest). While the alignment is steady, a new word appears every 10 clock cycles.
- R3: A comma is a group whose first seven received bits are 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0, that is `rx_word[6:0]` equal to 7'b1111100 or 7'b0000011. With `align_en` high, such a group appears on `rx_word` in the cycle after its tenth bit is sampled, at any bit offset, and the 10-cycle boundary restarts from it.
- R4: A comma group is always placed in the even slot. Other groups alternate odd/even. After an odd group, a correctly aligned comma raises `rclk_even` together with the comma word.
- R5: `comma_det` rises with the comma word and stays high until the next even-slot non-comma word appears, which is 20 cycles at steady alignment. `rx_word` holds a comma whenever `comma_det` rises.
- R6: While `align_en` is low, `comma_det` is 0 from the following cycle on and the word boundary does not move, even if a comma arrives at another offset.
- R7: `rclk_odd` is always the inverse of `rclk_even`. The even strobe follows the slot of the latest word, but neither level is ever held for fewer than 10 cycles. A strobe edge that would come early is delayed until the 10 cycles have passed.
- R8: `ser_out` equals `tx_bit` delayed by one cycle, whatever the value of `wrap_en`.
- R9: After reset: `rx_word`=0, `comma_det`=0, `rclk_even`=0, `rclk_odd`=1, `ser_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_bit | input | 1 | Recovered serial bit from the line |
| tx_bit | input | 1 | Serial bit of the local transmit stream |
| wrap_en | input | 1 | 1 = deserialize the transmit stream instead of the line |
| align_en | input | 1 | 1 = comma detection and realignment enabled |
| rx_word | output | GW | Aligned code-group, bit 0 received first |
| rclk_even | output | 1 | Half-rate strobe for even-slot groups |
| rclk_odd | output | 1 | Half-rate strobe for odd-slot groups, inverse of rclk_even |
| comma_det | output | 1 | High while a comma group is being presented |
| ser_out | output | 1 | Serial transmit output, tx_bit delayed one cycle |

## Verification
On every cycle the assertions check four things: the minimum strobe level width, the silence of the detect flag after the enable drops, that a detect rise always comes with a comma pattern on the word, and the one-cycle path from transmit input to serial output. Other behaviour depends on sequences of bits and only the bench scenarios can show it. This covers which word follows a comma at a new offset, the forced even slot, the 20-cycle detect window, the frozen boundary when alignment is disabled, and the choice of source under wrap. For these the bench compares every output cycle by cycle with a behavioural model driven by groups serialized at shifted offsets.

// File: rtl/cdes_pkg.sv
package cdes_pkg;
    localparam int COMMA_W = 7;
    // first received bit sits in bit 0
    localparam logic [COMMA_W-1:0] COMMA_LOW_RUN  = 7'b1111100;
    localparam logic [COMMA_W-1:0] COMMA_HIGH_RUN = 7'b0000011;

    typedef enum logic {
        SLOT_ODD  = 1'b0,
        SLOT_EVEN = 1'b1
    } slot_e;

    function automatic logic is_comma(input logic [COMMA_W-1:0] w);
        return (w == COMMA_LOW_RUN) || (w == COMMA_HIGH_RUN);
    endfunction
endpackage

// File: rtl/cdes_shift.sv
module cdes_shift #(
    parameter int GW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_bit,
    input  logic          tx_bit,
    input  logic          wrap_en,
    output logic [GW-1:0] win_nxt,
    output logic          ser_out
);
    typedef struct packed {
        logic [GW-1:0] sr;
        logic          ser;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      in_bit;

    always_comb begin
        st_d     = st_q;
        in_bit   = wrap_en ? tx_bit : line_bit;
        st_d.sr  = {in_bit, st_q.sr[GW-1:1]};
        st_d.ser = tx_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_nxt = st_d.sr;
    assign ser_out = st_q.ser;
endmodule

// File: rtl/cdes_frame.sv
module cdes_frame
    import cdes_pkg::*;
#(
    parameter int GW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] win_nxt,
    input  logic          align_en,
    output logic [GW-1:0] word,
    output logic          det,
    output slot_e         slot_nxt
);
    localparam int              CNT_W = $clog2(GW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GW - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        slot_e            slot;
        logic [GW-1:0]    word;
        logic             det;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic      hit, latch;

    always_comb begin
        st_d  = st_q;
        hit   = align_en && is_comma(win_nxt[COMMA_W-1:0]);
        latch = (st_q.cnt == LAST) || hit;
        if (latch) begin
            st_d.cnt  = '0;
            st_d.word = win_nxt;
            if (hit) begin
                st_d.slot = SLOT_EVEN;
                st_d.det  = 1'b1;
            end else begin
                st_d.slot = (st_q.slot == SLOT_EVEN) ? SLOT_ODD : SLOT_EVEN;
                if (st_d.slot == SLOT_EVEN) st_d.det = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!align_en) st_d.det = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.slot <= SLOT_ODD;
            st_q.word <= '0;
            st_q.det  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word     = st_q.word;
    assign det      = st_q.det;
    assign slot_nxt = st_d.slot;
endmodule

// File: rtl/cdes_clkgen.sv
module cdes_clkgen
    import cdes_pkg::*;
#(
    parameter int GW = 10
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_e slot_nxt,
    output logic  rclk_even,
    output logic  rclk_odd
);
    localparam int              AGE_W = $clog2(GW);
    localparam logic [AGE_W-1:0] HOLD = AGE_W'(GW - 1);

    typedef struct packed {
        logic             ph;
        logic [AGE_W-1:0] age;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    want;

    always_comb begin
        st_d = st_q;
        want = (slot_nxt == SLOT_EVEN);
        if ((st_q.ph != want) && (st_q.age == HOLD)) begin
            st_d.ph  = want;
            st_d.age = '0;
        end else if (st_q.age != HOLD) begin
            st_d.age = st_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= 1'b0;
            st_q.age <= HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rclk_even = st_q.ph;
    assign rclk_odd  = ~st_q.ph;
endmodule

// File: rtl/comma_deser.sv
module comma_deser
    import cdes_pkg::*;
#(
    parameter int GW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_bit,
    input  logic          tx_bit,
    input  logic          wrap_en,
    input  logic          align_en,
    output logic [GW-1:0] rx_word,
    output logic          rclk_even,
    output logic          rclk_odd,
    output logic          comma_det,
    output logic          ser_out
);
    logic [GW-1:0] win_nxt;
    slot_e         slot_nxt;

    cdes_shift #(.GW(GW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_bit (line_bit),
        .tx_bit   (tx_bit),
        .wrap_en  (wrap_en),
        .win_nxt  (win_nxt),
        .ser_out  (ser_out)
    );

    cdes_frame #(.GW(GW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_nxt  (win_nxt),
        .align_en (align_en),
        .word     (rx_word),
        .det      (comma_det),
        .slot_nxt (slot_nxt)
    );

    cdes_clkgen #(.GW(GW)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_nxt  (slot_nxt),
        .rclk_even (rclk_even),
        .rclk_odd  (rclk_odd)
    );
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk
    import cdes_pkg::*;
#(
    parameter int GW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_bit,
    input logic          align_en,
    input logic          rclk_even,
    input logic          comma_det,
    input logic          ser_out,
    input logic [GW-1:0] rx_word
);
    localparam int              RW  = $clog2(2 * GW + 1) + 1;
    localparam logic [RW-1:0]   CAP = RW'(2 * GW);

    logic          prev_even;
    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_even <= 1'b0;
            run       <= CAP;
        end else begin
            prev_even <= rclk_even;
            if (rclk_even != prev_even) run <= RW'(1);
            else if (run != CAP)        run <= run + 1'b1;
        end
    end

    a_r7_min_level: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk_even != prev_even) |-> (run >= RW'(GW)));

    a_r6_det_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en |=> !comma_det);

    a_r5_det_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comma_det) |-> is_comma(rx_word[COMMA_W-1:0]));

    a_r8_ser_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ser_out == $past(tx_bit)));
endmodule

bind comma_deser comma_deser_chk #(.GW(GW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_bit    (tx_bit),
    .align_en  (align_en),
    .rclk_even (rclk_even),
    .comma_det (comma_det),
    .ser_out   (ser_out),
    .rx_word   (rx_word)
);

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
    localparam logic [9:0] K285N = 10'b0101111100;
    localparam logic [9:0] K285P = 10'b1010000011;
    localparam logic [9:0] D215  = 10'b0101010101;
    localparam logic [9:0] D000  = 10'b0010111001;
    localparam logic [9:0] D102  = 10'b1010101010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit = 1'b0, tx_bit = 1'b0, wrap_en = 1'b0, align_en = 1'b0;
    logic [9:0] rx_word;
    logic       rclk_even, rclk_odd, comma_det, ser_out;

    int  checks = 0, fails = 0;
    bit  done = 0;

    comma_deser #(.GW(10)) dut (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .tx_bit(tx_bit),
        .wrap_en(wrap_en), .align_en(align_en), .rx_word(rx_word),
        .rclk_even(rclk_even), .rclk_odd(rclk_odd), .comma_det(comma_det),
        .ser_out(ser_out)
    );

    always #10 clk = ~clk;

    // behavioural reference
    bit         hist[$];
    int         m_cnt, m_age, run_len;
    bit         m_even, m_det, m_ph, m_ser, last_even;
    logic [9:0] m_word;

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < 10; i++) hist.push_back(1'b0);
        m_cnt = 0; m_age = 9; m_even = 0; m_det = 0; m_ph = 0; m_ser = 0; m_word = '0;
        run_len = 10; last_even = 0;
    endtask

    task automatic model_step(input bit lb, input bit tb, input bit wr, input bit al);
        bit b, hit, latch, nxt_even;
        b = wr ? tb : lb;
        hist.push_back(b);
        void'(hist.pop_front());
        hit = al && ((hist[0:6] == '{0,0,1,1,1,1,1}) || (hist[0:6] == '{1,1,0,0,0,0,0}));
        latch = (m_cnt == 9) || hit;
        nxt_even = m_even;
        if (latch) begin
            for (int i = 0; i < 10; i++) m_word[i] = hist[i];
            m_cnt = 0;
            nxt_even = hit ? 1'b1 : !m_even;
            if (hit) m_det = 1;
            else if (nxt_even) m_det = 0;
        end else m_cnt++;
        if (!al) m_det = 0;
        m_even = nxt_even;
        if ((m_ph != nxt_even) && (m_age >= 9)) begin m_ph = nxt_even; m_age = 0; end
        else if (m_age < 9) m_age++;
        m_ser = tb;
    endtask

    task automatic compare();
        chk(rx_word == m_word, "R2/R3 word", rx_word, m_word);
        chk(comma_det == m_det, "R5 detect", {9'd0, comma_det}, {9'd0, m_det});
        chk(rclk_even == m_ph, "R7 even strobe", {9'd0, rclk_even}, {9'd0, m_ph});
        chk(rclk_odd == !rclk_even, "R7 odd inverse", {9'd0, rclk_odd}, {9'd0, !rclk_even});
        chk(ser_out == m_ser, "R8 serial out", {9'd0, ser_out}, {9'd0, m_ser});
        if (rclk_even != last_even) begin
            chk(run_len >= 10, "R7 min level", 10'(run_len), 10'd10);
            run_len = 1;
        end else run_len++;
        last_even = rclk_even;
    endtask

    task automatic cyc(input bit lb, input bit tb, input bit wr, input bit al);
        line_bit = lb; tx_bit = tb; wrap_en = wr; align_en = al;
        model_step(lb, tb, wr, al);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic send_group(input logic [9:0] g, input bit wr, input bit al, input bit on_tx);
        for (int i = 0; i < 10; i++)
            cyc(on_tx ? 1'b1 : g[i], on_tx ? g[i] : 1'b0, wr, al);
    endtask

    task automatic send_bits(input int n, input bit wr, input bit al, input bit on_tx);
        for (int i = 0; i < n; i++)
            cyc(on_tx ? 1'b1 : i[0], on_tx ? i[0] : 1'b0, wr, al);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(rx_word == '0, "R9 word", rx_word, '0);
        chk(!comma_det, "R9 detect", {9'd0, comma_det}, '0);
        chk(!rclk_even && rclk_odd, "R9 strobes", {8'd0, rclk_even, rclk_odd}, 10'd1);
        chk(!ser_out, "R9 serial", {9'd0, ser_out}, '0);
        rst_n = 1'b1;

        // R3: comma at a shifted offset on the line
        send_bits(3, 0, 1, 0);
        send_group(K285N, 0, 1, 0);
        chk(rx_word == K285N, "R3 comma word", rx_word, K285N);
        chk(comma_det, "R3 detect", {9'd0, comma_det}, 10'd1);
        send_group(D215, 0, 1, 0);
        chk(rx_word == D215, "R2 next word", rx_word, D215);
        chk(comma_det, "R5 detect held on odd", {9'd0, comma_det}, 10'd1);
        send_group(D000, 0, 1, 0);
        chk(!comma_det, "R5 detect drops on even", {9'd0, comma_det}, '0);
        send_group(D102, 0, 1, 0);
        // R4: aligned comma after an odd group
        send_group(K285P, 0, 1, 0);
        chk(rx_word == K285P, "R4 comma word", rx_word, K285P);
        chk(rclk_even && !rclk_odd, "R4 even strobe", {8'd0, rclk_even, rclk_odd}, 10'd2);
        send_group(D215, 0, 1, 0);
        send_group(D000, 0, 1, 0);

        // R3: realign at another offset
        send_bits(4, 0, 1, 0);
        send_group(K285N, 0, 1, 0);
        chk(rx_word == K285N, "R3 realigned word", rx_word, K285N);
        for (int k = 0; k < 4; k++) send_group(k[0] ? D000 : D215, 0, 1, 0);

        // R6: alignment frozen
        send_bits(3, 0, 0, 0);
        send_group(K285N, 0, 0, 0);
        chk(!comma_det, "R6 no detect", {9'd0, comma_det}, '0);
        chk(rx_word != K285N, "R6 boundary held", rx_word, K285N);
        for (int k = 0; k < 3; k++) send_group(D215, 0, 0, 0);
        chk(!comma_det, "R6 still quiet", {9'd0, comma_det}, '0);

        // R1: wrap selects the transmit stream
        send_bits(2, 1, 1, 1);
        send_group(K285P, 1, 1, 1);
        chk(rx_word == K285P, "R1 wrapped comma", rx_word, K285P);
        send_group(D102, 1, 1, 1);
        send_group(D000, 1, 1, 1);

        // R1: without wrap the transmit stream is ignored
        for (int k = 0; k < 4; k++) send_group(K285N, 0, 1, 1);
        chk(rx_word == 10'h3FF, "R1 tx ignored", rx_word, 10'h3FF);
        chk(!comma_det, "R1 no detect from tx", {9'd0, comma_det}, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule